// File: doc/BRIEF.md
# CardBus Bridge Configuration Header Emulator

This block answers configuration accesses for a CardBus bridge that exists only as registers. A request addressed to the header slot on the root bus is served locally. Identity, class, header-type and status fields are constants. Command, bridge control, the four bus-number bytes and eight window registers are stored and can be written. Every request is accepted in its cycle, and exactly one result appears one clock later: either a local response or a forwarded cycle.

The bridge has one downstream device. Once a nonzero CardBus bus number has been written, a request to that bus number at slot 0 is re-issued on the forwarding port as a type 0 configuration cycle on bus 0, at a fixed IDSEL slot and function 0. Offset, size, direction and write data pass through unchanged. Any request that matches neither the header nor the downstream device gets a "not found" response.

Partial writes are merged into the current 32-bit image of the addressed dword before the stored fields are updated. Some fields are adjusted on the way in or out. The I/O base registers advertise 32-bit decoding, and the prefetch enables in bridge control are always cleared.

Top module: `cb_bridge_cfg`

## Requirements
- R1: Each cycle with `req_valid` high gives, on the next clock, exactly one of `rsp_valid` or `fwd_valid` high. A cycle with `req_valid` low gives neither.
- R2: A request with `req_root` high and `req_slot` equal to HDR_SLOT (default 0x1E) is served locally with `rsp_hit`=1, and `hdr_bus` takes that request's `req_bus` on the same clock. This match has priority over forwarding.
- R3: Dword offsets 0x00 and 0x40 read {DEVICE_ID, VENDOR_ID}. Offset 0x08 reads 0x0607_0000 and offset 0x0C reads 0x0002_0000. Writes to all four are ignored.
- R4: Offset 0x04 reads 0x0400 in bits 31:16 and the stored command in bits 15:0. A write stores bits 15:0 of the merged word.
- R5: Offset 0x3C reads {bridge control, 8'h01, 8'hFF}. A write stores merged bits 31:16 into bridge control with bits 8 and 9 of bridge control (dword bits 24 and 25) forced to 0.
- R6: Offset 0x18 holds latency[31:24], subordinate bus[23:16], CardBus bus[15:8] and primary bus[7:0]. A write whose merged bits 15:8 are nonzero sets the assigned flag. A later write cannot clear it.
- R7: Offsets 0x1C, 0x20, 0x24, 0x28, 0x30 and 0x38 read back the last value written. The I/O base registers at 0x2C and 0x34 read with bit 0 set to 1.
- R8: `req_size` encodes 0=byte, 1=halfword, 2 or 3=dword. Local read data is the dword shifted right by 8×`req_offset[1:0]` and masked to 8 or 16 bits; dword reads are unshifted. A local write returns `rsp_rdata`=0.
- R9: A byte or halfword write replaces only the lanes from 8×`req_offset[1:0]` upward that lie within the dword. Write-data bits above the access size are ignored, so a halfword at byte 3 changes only byte 3.
- R10: Header offsets not listed in R3–R7 read as zero and ignore writes.
- R11: With the assigned flag set, a non-header request whose `req_bus` equals the stored CardBus bus and whose `req_slot` is 0 yields `fwd_valid`. It carries `fwd_bus`=0, `fwd_slot`=FWD_IDSEL (default 16) and `fwd_func`=0, plus the request's write flag, offset, size and data.
- R12: Any other request gives `rsp_valid` with `rsp_hit`=0 and `rsp_rdata`=0. This includes device-slot requests made before the assigned flag is set.
- R13: After reset, all stored registers, `hdr_bus` and the assigned flag are zero, and no result is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_root | input | 1 | Request targets the root bus (bus without a parent) |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 5 | Target slot (device number) |
| req_offset | input | 8 | Byte offset in configuration space |
| req_size | input | 2 | Access size code (R8) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Local response valid |
| rsp_hit | output | 1 | 1 = header answered, 0 = device not found |
| rsp_rdata | output | 32 | Read data, right-aligned |
| hdr_bus | output | 8 | Root bus number seen on the last header access |
| fwd_valid | output | 1 | Forwarded type 0 cycle valid |
| fwd_write | output | 1 | Direction of the forwarded cycle |
| fwd_bus | output | 8 | Bus of the forwarded cycle (always 0) |
| fwd_slot | output | 5 | IDSEL slot of the forwarded cycle |
| fwd_func | output | 3 | Function of the forwarded cycle (always 0) |
| fwd_offset | output | 8 | Byte offset passed through |
| fwd_size | output | 2 | Size code passed through |
| fwd_wdata | output | 32 | Write data passed through |

## Verification
Two functions can meet in back-to-back cycles. In one cycle a header write changes the CardBus bus number. In the next cycle, the forwarding decision must already use the new number. The bench writes a single byte that moves the bus number from 3 to 4. On the very next clock it sends a request to bus 4 and expects a forwarded cycle, then a request to bus 3 and expects "not found". A later byte write sets the bus number to zero. A request to bus 0 must still forward, because the assigned flag stays set.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

  localparam int DATA_W = 32;
  localparam int OFF_W  = 8;
  localparam int BUS_W  = 8;
  localparam int SLOT_W = 5;
  localparam int DW_W   = OFF_W - 2;

  typedef enum logic [1:0] {RT_IDLE, RT_HDR, RT_FWD, RT_MISS} route_e;

  // dword indices decoded by standard configuration software
  localparam logic [DW_W-1:0] DW_ID        = 6'd0;
  localparam logic [DW_W-1:0] DW_CMD       = 6'd1;
  localparam logic [DW_W-1:0] DW_CLASS     = 6'd2;
  localparam logic [DW_W-1:0] DW_HDR       = 6'd3;
  localparam logic [DW_W-1:0] DW_BUS       = 6'd6;
  localparam logic [DW_W-1:0] DW_WIN_FIRST = 6'd7;
  localparam logic [DW_W-1:0] DW_WIN_LAST  = 6'd14;
  localparam logic [DW_W-1:0] DW_INTR      = 6'd15;
  localparam logic [DW_W-1:0] DW_SUBSYS    = 6'd16;

  localparam logic [15:0] STATUS_DEVSEL_SLOW = 16'h0400;
  localparam logic [15:0] CLASS_CB_BRIDGE    = 16'h0607;
  localparam logic [7:0]  HDR_TYPE_CB        = 8'h02;
  localparam logic [7:0]  INT_PIN_A          = 8'h01;
  localparam logic [7:0]  INT_LINE_NONE      = 8'hFF;
  localparam logic [15:0] BRCTL_PREFETCH     = 16'h0300;

  function automatic logic [DATA_W-1:0] cbb_lane_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    case (sz)
      2'b00:   m = 32'h0000_00FF;
      2'b01:   m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] cbb_extract(input logic [DATA_W-1:0] word,
                                                    input logic [1:0] sz,
                                                    input logic [1:0] bo);
    logic [4:0] sh;
    sh = {bo, 3'b000};
    if (sz[1]) return word;
    return (word >> sh) & cbb_lane_mask(sz);
  endfunction

  function automatic logic [DATA_W-1:0] cbb_merge(input logic [DATA_W-1:0] orig,
                                                  input logic [DATA_W-1:0] val,
                                                  input logic [1:0] sz,
                                                  input logic [1:0] bo);
    logic [4:0]        sh;
    logic [DATA_W-1:0] m;
    sh = {bo, 3'b000};
    m  = cbb_lane_mask(sz);
    if (sz[1]) return val;
    return (orig & ~(m << sh)) | ((val & m) << sh);
  endfunction

endpackage

// File: rtl/cbb_decode.sv
module cbb_decode
  import cbb_pkg::*;
#(
  parameter logic [SLOT_W-1:0] HDR_SLOT = 5'h1E,
  parameter logic [SLOT_W-1:0] DEV_SLOT = 5'h00
) (
  input  logic              req_valid,
  input  logic              req_root,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [BUS_W-1:0]  cb_bus,
  input  logic              assigned,
  output route_e            route
);

  logic hdr_match;
  logic dev_match;

  assign hdr_match = req_root && (req_slot == HDR_SLOT);
  assign dev_match = assigned && (req_bus == cb_bus) && (req_slot == DEV_SLOT);

  always_comb begin
    if (!req_valid)     route = RT_IDLE;
    else if (hdr_match) route = RT_HDR;
    else if (dev_match) route = RT_FWD;
    else                route = RT_MISS;
  end

endmodule

// File: rtl/cbb_regs.sv
module cbb_regs
  import cbb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1A5C,
  parameter logic [15:0] DEVICE_ID = 16'h0C35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW_W-1:0]   dw_idx,
  input  logic [1:0]        sz,
  input  logic [1:0]        bo,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic [BUS_W-1:0]  cb_bus,
  output logic              assigned
);

  localparam int NUM_WIN = int'(DW_WIN_LAST - DW_WIN_FIRST) + 1;
  localparam int WSEL_W  = $clog2(NUM_WIN);

  logic [15:0]       cmd_q, cmd_d;
  logic [15:0]       brctl_q, brctl_d;
  logic [7:0]        lat_q, lat_d, sub_q, sub_d, cbus_q, cbus_d, pbus_q, pbus_d;
  logic              asg_q, asg_d;
  logic [DATA_W-1:0] win_q  [NUM_WIN];
  logic [DATA_W-1:0] win_rd [NUM_WIN];
  logic [NUM_WIN-1:0] win_we;

  logic              win_hit;
  logic [WSEL_W-1:0] win_sel;
  logic [DATA_W-1:0] merged;
  logic              cmd_we, brctl_we, bus_we;

  assign win_hit = (dw_idx >= DW_WIN_FIRST) && (dw_idx <= DW_WIN_LAST);
  assign win_sel = WSEL_W'(dw_idx - DW_WIN_FIRST);

  // read image of the addressed dword
  always_comb begin
    case (dw_idx)
      DW_ID, DW_SUBSYS: rd_word = {DEVICE_ID, VENDOR_ID};
      DW_CMD:           rd_word = {STATUS_DEVSEL_SLOW, cmd_q};
      DW_CLASS:         rd_word = {CLASS_CB_BRIDGE, 16'h0000};
      DW_HDR:           rd_word = {8'h00, HDR_TYPE_CB, 16'h0000};
      DW_BUS:           rd_word = {lat_q, sub_q, cbus_q, pbus_q};
      DW_INTR:          rd_word = {brctl_q, INT_PIN_A, INT_LINE_NONE};
      default:          rd_word = win_hit ? win_rd[win_sel] : '0;
    endcase
  end

  assign merged   = cbb_merge(rd_word, wdata, sz, bo);
  assign cmd_we   = wr_en && (dw_idx == DW_CMD);
  assign brctl_we = wr_en && (dw_idx == DW_INTR);
  assign bus_we   = wr_en && (dw_idx == DW_BUS);

  // next-state logic
  always_comb begin
    cmd_d   = cmd_q;
    brctl_d = brctl_q;
    lat_d   = lat_q;
    sub_d   = sub_q;
    cbus_d  = cbus_q;
    pbus_d  = pbus_q;
    asg_d   = asg_q;
    if (cmd_we)   cmd_d   = merged[15:0];
    if (brctl_we) brctl_d = merged[31:16] & ~BRCTL_PREFETCH;
    if (bus_we) begin
      lat_d  = merged[31:24];
      sub_d  = merged[23:16];
      cbus_d = merged[15:8];
      pbus_d = merged[7:0];
      if (merged[15:8] != 8'h00) asg_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      brctl_q <= '0;
      lat_q   <= '0;
      sub_q   <= '0;
      cbus_q  <= '0;
      pbus_q  <= '0;
      asg_q   <= 1'b0;
    end else begin
      if (cmd_we)   cmd_q   <= cmd_d;
      if (brctl_we) brctl_q <= brctl_d;
      if (bus_we) begin
        lat_q  <= lat_d;
        sub_q  <= sub_d;
        cbus_q <= cbus_d;
        pbus_q <= pbus_d;
        asg_q  <= asg_d;
      end
    end
  end

  // window base/limit registers; odd-numbered I/O bases force bit 0
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam bit IS_IO_BASE = (g == 4) || (g == 6);
    assign win_we[g] = wr_en && win_hit && (win_sel == WSEL_W'(g));
    if (IS_IO_BASE) begin : g_io
      assign win_rd[g] = win_q[g] | 32'h1;
    end else begin : g_plain
      assign win_rd[g] = win_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         win_q[g] <= '0;
      else if (win_we[g]) win_q[g] <= merged;
    end
  end

  assign cb_bus   = cbus_q;
  assign assigned = asg_q;

  // R6: the assigned flag never drops once set
  a_r6_sticky_assigned: assert property (@(posedge clk) disable iff (!rst_n)
    asg_q |=> asg_q);

  // R5: bridge control never holds a prefetch enable
  a_r5_brctl_clean: assert property (@(posedge clk) disable iff (!rst_n)
    brctl_we |=> ((brctl_q & BRCTL_PREFETCH) == 16'h0));

endmodule

// File: rtl/cbb_rsp.sv
module cbb_rsp
  import cbb_pkg::*;
#(
  parameter logic [SLOT_W-1:0] FWD_IDSEL = 5'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  route_e            route,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0]  hdr_bus,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [BUS_W-1:0]  fwd_bus,
  output logic [SLOT_W-1:0] fwd_slot,
  output logic [2:0]        fwd_func,
  output logic [OFF_W-1:0]  fwd_offset,
  output logic [1:0]        fwd_size,
  output logic [DATA_W-1:0] fwd_wdata
);

  logic              rv_d, hit_d, fv_d, hdr_en;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rv_d    = (route == RT_HDR) || (route == RT_MISS);
    hit_d   = (route == RT_HDR);
    fv_d    = (route == RT_FWD);
    hdr_en  = (route == RT_HDR);
    rdata_d = '0;
    if (hit_d && !req_write)
      rdata_d = cbb_extract(rd_word, req_size, req_offset[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
      hdr_bus   <= '0;
      fwd_valid <= 1'b0;
    end else begin
      rsp_valid <= rv_d;
      rsp_hit   <= hit_d;
      fwd_valid <= fv_d;
      if (rv_d)   rsp_rdata <= rdata_d;
      if (hdr_en) hdr_bus   <= req_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_write  <= 1'b0;
      fwd_bus    <= '0;
      fwd_slot   <= '0;
      fwd_func   <= '0;
      fwd_offset <= '0;
      fwd_size   <= '0;
      fwd_wdata  <= '0;
    end else if (fv_d) begin
      fwd_write  <= req_write;
      fwd_bus    <= '0;
      fwd_slot   <= FWD_IDSEL;
      fwd_func   <= '0;
      fwd_offset <= req_offset;
      fwd_size   <= req_size;
      fwd_wdata  <= req_wdata;
    end
  end

endmodule

// File: rtl/cb_bridge_cfg.sv
module cb_bridge_cfg
  import cbb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1A5C,
  parameter logic [15:0] DEVICE_ID = 16'h0C35,
  parameter logic [4:0]  HDR_SLOT  = 5'h1E,
  parameter logic [4:0]  DEV_SLOT  = 5'h00,
  parameter logic [4:0]  FWD_IDSEL = 5'd16
) (
  input  logic        clk,
  input  logic        rst_n_i,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_root,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_slot,
  input  logic [7:0]  req_offset,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [31:0] rsp_rdata,
  output logic [7:0]  hdr_bus,
  output logic        fwd_valid,
  output logic        fwd_write,
  output logic [7:0]  fwd_bus,
  output logic [4:0]  fwd_slot,
  output logic [2:0]  fwd_func,
  output logic [7:0]  fwd_offset,
  output logic [1:0]  fwd_size,
  output logic [31:0] fwd_wdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  route_e            route;
  logic [BUS_W-1:0]  cb_bus;
  logic              assigned;
  logic [DATA_W-1:0] rd_word;
  logic              hdr_wr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cbb_decode #(.HDR_SLOT(HDR_SLOT), .DEV_SLOT(DEV_SLOT)) u_decode (
    .req_valid (req_valid),
    .req_root  (req_root),
    .req_bus   (req_bus),
    .req_slot  (req_slot),
    .cb_bus    (cb_bus),
    .assigned  (assigned),
    .route     (route)
  );

  assign hdr_wr = (route == RT_HDR) && req_write;

  cbb_regs #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (hdr_wr),
    .dw_idx   (req_offset[OFF_W-1:2]),
    .sz       (req_size),
    .bo       (req_offset[1:0]),
    .wdata    (req_wdata),
    .rd_word  (rd_word),
    .cb_bus   (cb_bus),
    .assigned (assigned)
  );

  cbb_rsp #(.FWD_IDSEL(FWD_IDSEL)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .route      (route),
    .req_write  (req_write),
    .req_bus    (req_bus),
    .req_offset (req_offset),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rd_word    (rd_word),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_rdata  (rsp_rdata),
    .hdr_bus    (hdr_bus),
    .fwd_valid  (fwd_valid),
    .fwd_write  (fwd_write),
    .fwd_bus    (fwd_bus),
    .fwd_slot   (fwd_slot),
    .fwd_func   (fwd_func),
    .fwd_offset (fwd_offset),
    .fwd_size   (fwd_size),
    .fwd_wdata  (fwd_wdata)
  );

  // R1: never both result kinds at once
  a_r1_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, fwd_valid}));

  // R1: every request produces a result on the next clock
  a_r1_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid || fwd_valid));

  // R1: no result without a request
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_valid || fwd_valid));

  // R7: dword read of the first I/O base shows bit 0 set
  a_r7_io_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_root && req_slot == HDR_SLOT &&
     req_offset == 8'h2C && req_size == 2'b10) |=> rsp_rdata[0]);

  // R5: dword read of bridge control never shows prefetch enables
  a_r5_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_root && req_slot == HDR_SLOT &&
     req_offset == 8'h3C && req_size == 2'b10) |=> (rsp_rdata[25:24] == 2'b00));

  // R11: nothing is forwarded before a bus number is assigned
  a_r11_fwd_needs_assigned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !assigned) |=> !fwd_valid);

endmodule

// File: tb/cb_bridge_cfg_test.sv
module cb_bridge_cfg_test;

  localparam logic [31:0] ID_WORD = 32'h0C35_1A5C;
  localparam logic [4:0]  HDR     = 5'h1E;
  localparam logic [4:0]  IDSEL   = 5'd16;

  logic        clk = 1'b0;
  logic        rst_n_i = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_root = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_slot = '0;
  logic [7:0]  req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_hit, fwd_valid, fwd_write;
  logic [31:0] rsp_rdata, fwd_wdata;
  logic [7:0]  hdr_bus, fwd_bus, fwd_offset;
  logic [4:0]  fwd_slot;
  logic [2:0]  fwd_func;
  logic [1:0]  fwd_size;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;

  typedef struct {
    int          due;
    bit          is_fwd;
    bit          hit;
    logic [31:0] data;
    bit          wr;
    logic [7:0]  off;
    logic [1:0]  sz;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  cb_bridge_cfg uut (
    .clk(clk), .rst_n_i(rst_n_i),
    .req_valid(req_valid), .req_write(req_write), .req_root(req_root),
    .req_bus(req_bus), .req_slot(req_slot), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .hdr_bus(hdr_bus),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_bus(fwd_bus),
    .fwd_slot(fwd_slot), .fwd_func(fwd_func), .fwd_offset(fwd_offset),
    .fwd_size(fwd_size), .fwd_wdata(fwd_wdata)
  );

  task automatic check(input bit ok, input string tag, input string detail);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  // driver: one request per call, expected result queued for the next clock
  task automatic send(input bit wr, input bit root, input logic [7:0] bus,
                      input logic [4:0] slot, input logic [7:0] off,
                      input logic [1:0] sz, input logic [31:0] wd,
                      input bit efwd, input bit ehit, input logic [31:0] edata,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_root = root; req_bus = bus;
    req_slot = slot; req_offset = off; req_size = sz; req_wdata = wd;
    e.due = cyc + 1; e.is_fwd = efwd; e.hit = ehit; e.data = edata;
    e.wr = wr; e.off = off; e.sz = sz; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hrd(input logic [7:0] off, input logic [1:0] sz,
                     input logic [31:0] edata, input string tag);
    send(1'b0, 1'b1, 8'h00, HDR, off, sz, 32'h0, 1'b0, 1'b1, edata, tag);
  endtask

  task automatic hwr(input logic [7:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, input string tag);
    send(1'b1, 1'b1, 8'h00, HDR, off, sz, wd, 1'b0, 1'b1, 32'h0, tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // monitor: compares results against the queue head when it falls due
  initial begin
    forever begin
      @(posedge clk); #3;
      if (mon_on) begin
        if (q.size() > 0 && q[0].due == cyc) begin
          exp_t e;
          e = q.pop_front();
          if (e.is_fwd)
            check(fwd_valid && !rsp_valid && fwd_write == e.wr && fwd_bus == 8'h00 &&
                  fwd_slot == IDSEL && fwd_func == 3'd0 && fwd_offset == e.off &&
                  fwd_size == e.sz && (!e.wr || fwd_wdata == e.data), e.tag,
                  $sformatf("fwd got v=%0b r=%0b w=%0b bus=%h slot=%h func=%0d off=%h sz=%0d wd=%h exp w=%0b off=%h sz=%0d wd=%h",
                            fwd_valid, rsp_valid, fwd_write, fwd_bus, fwd_slot, fwd_func,
                            fwd_offset, fwd_size, fwd_wdata, e.wr, e.off, e.sz, e.data));
          else
            check(rsp_valid && !fwd_valid && rsp_hit == e.hit && rsp_rdata == e.data, e.tag,
                  $sformatf("rsp got v=%0b f=%0b hit=%0b data=%h exp hit=%0b data=%h",
                            rsp_valid, fwd_valid, rsp_hit, rsp_rdata, e.hit, e.data));
        end else begin
          check(!rsp_valid && !fwd_valid, "R1 idle",
                $sformatf("got rsp_valid=%0b fwd_valid=%0b exp 0 0", rsp_valid, fwd_valid));
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n_i = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    check(!rsp_valid && !fwd_valid && hdr_bus == 8'h00, "R13 reset",
          $sformatf("got rv=%0b fv=%0b hdr_bus=%h exp 0 0 00", rsp_valid, fwd_valid, hdr_bus));
    mon_on = 1'b1;

    // R13: stored registers start at zero
    hrd(8'h18, 2'b10, 32'h0, "R13 bus dword");
    hrd(8'h24, 2'b10, 32'h0, "R13 mem base1");
    hrd(8'h04, 2'b10, 32'h0400_0000, "R13 command");
    // R3: fixed identity fields, writes ignored
    hrd(8'h00, 2'b10, ID_WORD, "R3 id");
    hrd(8'h40, 2'b10, ID_WORD, "R3 subsys id");
    hrd(8'h08, 2'b10, 32'h0607_0000, "R3 class");
    hrd(8'h0C, 2'b10, 32'h0002_0000, "R3 header type");
    hwr(8'h00, 2'b10, 32'hFFFF_FFFF, "R3 id write");
    hwr(8'h08, 2'b10, 32'hFFFF_FFFF, "R3 class write");
    hrd(8'h00, 2'b10, ID_WORD, "R3 id after write");
    hrd(8'h08, 2'b10, 32'h0607_0000, "R3 class after write");
    // R4 / R8: command, sub-word reads
    hwr(8'h04, 2'b10, 32'h1234_5678, "R4 cmd write");
    hrd(8'h04, 2'b10, 32'h0400_5678, "R4 cmd read");
    hrd(8'h06, 2'b00, 32'h0000_0000, "R8 byte 2");
    hrd(8'h07, 2'b00, 32'h0000_0004, "R8 byte 3");
    hrd(8'h04, 2'b01, 32'h0000_5678, "R8 half 0");
    // R5: bridge control strips prefetch enables
    hwr(8'h3C, 2'b10, 32'hFFFF_0000, "R5 brctl write");
    hrd(8'h3C, 2'b10, 32'hFCFF_01FF, "R5 brctl read");
    // R7: windows
    hwr(8'h1C, 2'b10, 32'hA5A5_1234, "R7 mem base0 write");
    hwr(8'h2C, 2'b10, 32'h0000_1000, "R7 io base0 write");
    hwr(8'h30, 2'b10, 32'hDEAD_BEEF, "R7 io lim0 write");
    hrd(8'h1C, 2'b10, 32'hA5A5_1234, "R7 mem base0 read");
    hrd(8'h2C, 2'b10, 32'h0000_1001, "R7 io base0 bit0");
    hrd(8'h30, 2'b10, 32'hDEAD_BEEF, "R7 io lim0 read");
    hrd(8'h34, 2'b10, 32'h0000_0001, "R7 io base1 bit0");
    // R9: merged sub-word writes into mem limit 0
    hwr(8'h21, 2'b00, 32'hFFFF_FF99, "R9 byte write");
    hrd(8'h20, 2'b10, 32'h0000_9900, "R9 after byte");
    hwr(8'h22, 2'b01, 32'h0000_BEEF, "R9 half write");
    hwr(8'h23, 2'b01, 32'h0000_1177, "R9 half at byte 3");
    hrd(8'h20, 2'b10, 32'h77EF_9900, "R9 merged word");
    hrd(8'h22, 2'b01, 32'h0000_77EF, "R8 half at 2");
    hrd(8'h23, 2'b01, 32'h0000_0077, "R8 half at 3");
    // R10: undefined offsets
    hwr(8'h10, 2'b10, 32'hFFFF_FFFF, "R10 write hole");
    hrd(8'h10, 2'b10, 32'h0, "R10 read hole");
    hrd(8'h44, 2'b10, 32'h0, "R10 read 0x44");
    // R12: no bus assigned yet
    send(1'b0, 1'b0, 8'h00, 5'h00, 8'h00, 2'b10, 32'h0, 1'b0, 1'b0, 32'h0, "R12 before assign");
    send(1'b0, 1'b1, 8'h00, 5'h1D, 8'h00, 2'b10, 32'h0, 1'b0, 1'b0, 32'h0, "R12 wrong slot");
    // R6: bus numbers, assignment
    hwr(8'h18, 2'b10, 32'h4005_0300, "R6 bus write");
    hrd(8'h18, 2'b10, 32'h4005_0300, "R6 bus read");
    // back-to-back: new bus number used by the very next request
    hwr(8'h19, 2'b00, 32'h0000_0004, "R9 cb bus byte");
    send(1'b0, 1'b0, 8'h04, 5'h00, 8'h00, 2'b10, 32'h0, 1'b1, 1'b0, 32'h0, "R11 fwd new bus");
    send(1'b0, 1'b0, 8'h03, 5'h00, 8'h00, 2'b10, 32'h0, 1'b0, 1'b0, 32'h0, "R12 old bus");
    send(1'b0, 1'b0, 8'h04, 5'h01, 8'h00, 2'b10, 32'h0, 1'b0, 1'b0, 32'h0, "R12 slot 1");
    send(1'b1, 1'b0, 8'h04, 5'h00, 8'h11, 2'b00, 32'h0000_005A, 1'b1, 1'b0, 32'h0000_005A, "R11 fwd write");
    hrd(8'h18, 2'b10, 32'h4005_0400, "R6 bus after byte");
    // R6: zero bus number keeps the flag
    hwr(8'h19, 2'b00, 32'h0, "R6 cb bus zero");
    send(1'b0, 1'b0, 8'h00, 5'h00, 8'h08, 2'b01, 32'h0, 1'b1, 1'b0, 32'h0, "R6 sticky fwd");
    send(1'b0, 1'b1, 8'h00, 5'h00, 8'h08, 2'b01, 32'h0, 1'b1, 1'b0, 32'h0, "R11 root slot 0 fwd");
    // R2: header priority and root bus capture
    send(1'b0, 1'b1, 8'h07, HDR, 8'h18, 2'b10, 32'h0, 1'b0, 1'b1, 32'h4005_0000, "R2 header read");
    idle();
    #2;
    check(hdr_bus == 8'h07, "R2 hdr_bus",
          $sformatf("got %h exp 07", hdr_bus));
    repeat (4) @(posedge clk);
    #4;
    check(q.size() == 0, "R1 drain", $sformatf("got %0d pending exp 0", q.size()));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule